// File: doc/BRIEF.md
# Push-Pull Pulse Steering Controller

This block turns one single-ended drive request into two gate-drive enables, A and B. The request is formed from an inverting input and a non-inverting input. In parallel mode both enables follow the request together. In alternating mode each qualified request pulse goes to one channel, and the next qualified pulse goes to the other channel. This converts a single-ended pulse train into push-pull drive.

The stop, per-channel inhibit and over-temperature flags arrive as digital flags. They are resynchronised together with the request. A stop flag latches a shutdown of both enables. The latch releases only after the request has stayed low for a configurable off-time. The same off-time gates whether a new request pulse is accepted at all. Two status outputs report the latch state and the channel currently selected.

Top module: `push_pull_steer`

## Requirements
- R1: While rst_ni is low, and directly after it rises, drive_a_o and drive_b_o are 0, stop_latched_o is 0 and sel_b_o is 0, meaning channel A is selected.
- R2: The request is active only when noninv_i=1 and inv_i=0. The combinations (1,1), (0,0) and (inv_i=1, noninv_i=0) leave both enables at 0.
- R3: With alt_mode_i=0 (parallel), a qualified pulse drives drive_a_o and drive_b_o high together for as long as the request lasts.
- R4: With alt_mode_i=1, the first qualified pulse after reset drives only channel A. Each later qualified pulse drives only the other channel. sel_b_o toggles when a qualified pulse ends.
- R5: A request rising edge is qualified only if the synchronised request has been low for at least OFF_CYCLES clocks. An unqualified pulse keeps both enables at 0 for its whole length and leaves sel_b_o unchanged.
- R6: A stop flag sets stop_latched_o and forces both enables to 0. The latch holds until the request has been low for OFF_CYCLES clocks, and then clears.
- R7: While overtemp_i is high (after synchronisation), both enables are 0. They return without a new pulse if the request is still on when the flag drops.
- R8: inhibit_a_i holds only drive_a_o at 0, and inhibit_b_i holds only drive_b_o at 0.
- R9: A request edge reaches the enables 3 clocks after it is sampled. Inhibit and over-temperature flags act after 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | Inverting request input |
| noninv_i | input | 1 | Non-inverting request input |
| alt_mode_i | input | 1 | 1 = alternating steering, 0 = parallel |
| stop_i | input | 1 | Stop flag, latched |
| inhibit_a_i | input | 1 | Hold channel A off |
| inhibit_b_i | input | 1 | Hold channel B off |
| overtemp_i | input | 1 | Over-temperature force-off |
| drive_a_o | output | 1 | Channel A drive enable |
| drive_b_o | output | 1 | Channel B drive enable |
| stop_latched_o | output | 1 | Stop latch state |
| sel_b_o | output | 1 | Selected channel, 1 = B |

## Verification
The hardest situation to reach is a request pulse rejected because the preceding low gap was shorter than the off-time. Its effect shows up only as enables that stay low and a selector that does not move. The bench creates it with a deliberately short gap after a qualified pulse. It then follows with a long gap and checks that the next pulse lands on the channel the rejected pulse did not consume. The stop latch release is reached the same way. The request is held low for part of the off-time and then for all of it, and stop_latched_o is checked on both sides of the boundary. A behavioural model compares all four outputs on every clock.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;

  localparam int unsigned IDX_INV    = 0;
  localparam int unsigned IDX_NONINV = 1;
  localparam int unsigned IDX_MODE   = 2;
  localparam int unsigned IDX_STOP   = 3;
  localparam int unsigned IDX_INH_A  = 4;
  localparam int unsigned IDX_INH_B  = 5;
  localparam int unsigned IDX_OT     = 6;
  localparam int unsigned N_FLAGS    = 7;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("pps_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pps_offtime.sv
module pps_offtime #(
  parameter int unsigned OFF_CYCLES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic off_ok_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = $clog2(OFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OFF_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  // counter starts saturated so the first pulse after reset qualifies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_MAX;
      req_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (req_i)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign off_ok_o = (cnt_q == CNT_MAX);
  assign rise_o   = req_i & ~req_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_req_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !off_ok_o);
endmodule

// File: rtl/pps_steer.sv
module pps_steer
  import pps_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  rise_i,
  input  logic  off_ok_i,
  input  logic  alt_i,
  input  logic  stop_i,
  input  logic  inh_a_i,
  input  logic  inh_b_i,
  input  logic  ot_i,
  output logic  drv_a_o,
  output logic  drv_b_o,
  output logic  stop_lat_o,
  output chan_e sel_o
);
  logic  armed_q, stop_q;
  chan_e sel_q;
  logic  qualify, pulse_end;
  logic [1:0] inh, drv;

  assign qualify   = rise_i & off_ok_i;
  assign pulse_end = armed_q & ~req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sel_q   <= CH_A;
      stop_q  <= 1'b0;
    end else begin
      if (!req_i)       armed_q <= 1'b0;
      else if (qualify) armed_q <= 1'b1;
      // steering advances only when a qualified pulse finishes
      if (pulse_end && alt_i) sel_q <= (sel_q == CH_A) ? CH_B : CH_A;
      if (stop_i)        stop_q <= 1'b1;
      else if (off_ok_i) stop_q <= 1'b0;
    end
  end

  assign inh = {inh_b_i, inh_a_i};

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic chan_sel;
      if (ch == 0) begin : g_a
        assign chan_sel = (sel_q == CH_A);
      end else begin : g_b
        assign chan_sel = (sel_q == CH_B);
      end
      assign drv[ch] = armed_q & ~stop_q & ~ot_i & ~inh[ch] & (~alt_i | chan_sel);
    end
  endgenerate

  assign drv_a_o    = drv[0];
  assign drv_b_o    = drv[1];
  assign stop_lat_o = stop_q;
  assign sel_o      = sel_q;

  p_unarmed_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (drv == 2'b00));
  p_alt_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_i |-> !(drv_a_o && drv_b_o));
  p_sel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> ($past(armed_q) && !$past(req_i)));
  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !off_ok_i) |=> stop_q);
  p_ot_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> (drv == 2'b00));
  p_inh_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_a_i |-> !drv_a_o);
  p_inh_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_b_i |-> !drv_b_o);
endmodule

// File: rtl/push_pull_steer.sv
module push_pull_steer
  import pps_pkg::*;
#(
  parameter int unsigned OFF_CYCLES  = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inv_i,
  input  logic noninv_i,
  input  logic alt_mode_i,
  input  logic stop_i,
  input  logic inhibit_a_i,
  input  logic inhibit_b_i,
  input  logic overtemp_i,
  output logic drive_a_o,
  output logic drive_b_o,
  output logic stop_latched_o,
  output logic sel_b_o
);
  logic [N_FLAGS-1:0] raw_in, flg_s;
  logic  req_s, off_ok, rise;
  chan_e sel;

  always_comb begin
    raw_in             = '0;
    raw_in[IDX_INV]    = inv_i;
    raw_in[IDX_NONINV] = noninv_i;
    raw_in[IDX_MODE]   = alt_mode_i;
    raw_in[IDX_STOP]   = stop_i;
    raw_in[IDX_INH_A]  = inhibit_a_i;
    raw_in[IDX_INH_B]  = inhibit_b_i;
    raw_in[IDX_OT]     = overtemp_i;
  end

  pps_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(flg_s)
  );

  // R2: request only for non-inverting high with inverting low
  assign req_s = flg_s[IDX_NONINV] & ~flg_s[IDX_INV];

  pps_offtime #(.OFF_CYCLES(OFF_CYCLES)) i_offtime (
    .clk_i, .rst_ni, .req_i(req_s), .off_ok_o(off_ok), .rise_o(rise)
  );

  pps_steer i_steer (
    .clk_i, .rst_ni,
    .req_i(req_s), .rise_i(rise), .off_ok_i(off_ok),
    .alt_i(flg_s[IDX_MODE]), .stop_i(flg_s[IDX_STOP]),
    .inh_a_i(flg_s[IDX_INH_A]), .inh_b_i(flg_s[IDX_INH_B]), .ot_i(flg_s[IDX_OT]),
    .drv_a_o(drive_a_o), .drv_b_o(drive_b_o),
    .stop_lat_o(stop_latched_o), .sel_o(sel)
  );

  assign sel_b_o = (sel == CH_B);

  p_rst_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!drive_a_o && !drive_b_o && !stop_latched_o && !sel_b_o));
endmodule

// File: tb/test_push_pull_steer.sv
module test_push_pull_steer;
  import pps_pkg::*;
  localparam int unsigned OFF = 25;
  localparam time TCK = 8ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv = 0, noninv = 0, alt = 0, stp = 0, inh_a = 0, inh_b = 0, ot = 0;
  logic drive_a, drive_b, stop_l, sel_b;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  push_pull_steer #(.OFF_CYCLES(OFF)) i_push_pull_steer (
    .clk_i(clk), .rst_ni(rst_n), .inv_i(inv), .noninv_i(noninv),
    .alt_mode_i(alt), .stop_i(stp), .inhibit_a_i(inh_a), .inhibit_b_i(inh_b),
    .overtemp_i(ot), .drive_a_o(drive_a), .drive_b_o(drive_b),
    .stop_latched_o(stop_l), .sel_b_o(sel_b)
  );

  function automatic logic [N_FLAGS-1:0] raw_vec();
    logic [N_FLAGS-1:0] v;
    v = '0;
    v[IDX_INV] = inv;     v[IDX_NONINV] = noninv; v[IDX_MODE] = alt;
    v[IDX_STOP] = stp;    v[IDX_INH_A] = inh_a;   v[IDX_INH_B] = inh_b;
    v[IDX_OT] = ot;
    return v;
  endfunction

  // behavioural reference: input history plus pulse bookkeeping
  logic [N_FLAGS-1:0] hist[$];
  int m_low_run;
  bit m_on, m_sel, m_stop, m_prev;

  always @(posedge clk or negedge rst_n) begin : model
    logic [N_FLAGS-1:0] u;
    bit rq, enough;
    if (!rst_n) begin
      hist = {'0, '0, '0};
      m_low_run = OFF; m_on = 0; m_sel = 0; m_stop = 0; m_prev = 0;
    end else begin
      hist.push_back(raw_vec());
      u = hist[hist.size()-3];
      void'(hist.pop_front());
      rq = u[IDX_NONINV] && !u[IDX_INV];
      enough = (m_low_run >= OFF);
      if (u[IDX_STOP]) m_stop = 1;
      else if (enough) m_stop = 0;
      if (!rq) begin
        if (m_on && u[IDX_MODE]) m_sel = !m_sel;
        m_on = 0;
      end else if (!m_prev && enough) m_on = 1;
      m_prev = rq;
      m_low_run = rq ? 0 : ((m_low_run < OFF) ? m_low_run + 1 : OFF);
    end
  end

  always @(negedge clk) begin
    logic [N_FLAGS-1:0] v;
    logic ea, eb;
    if (rst_n && !done) begin
      v  = hist[1];
      ea = m_on && !m_stop && !v[IDX_OT] && !v[IDX_INH_A] && (!v[IDX_MODE] || !m_sel);
      eb = m_on && !m_stop && !v[IDX_OT] && !v[IDX_INH_B] && (!v[IDX_MODE] ||  m_sel);
      checks++;
      if ({drive_a, drive_b, stop_l, sel_b} !== {ea, eb, m_stop, m_sel}) begin
        fails++;
        $display("FAIL %s model t=%0t actual=%b%b%b%b expected=%b%b%b%b", cur_req, $time,
                 drive_a, drive_b, stop_l, sel_b, ea, eb, m_stop, m_sel);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1", "a in reset", drive_a, 1'b0);
    chk("R1", "b in reset", drive_b, 1'b0);
    chk("R1", "sel in reset", sel_b, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "stop after reset", stop_l, 1'b0);

    cur_req = "R2";
    inv = 1; noninv = 1; idle(6);
    chk("R2", "a inv=1 ni=1", drive_a, 1'b0);
    chk("R2", "b inv=1 ni=1", drive_b, 1'b0);
    inv = 1; noninv = 0; idle(6);
    chk("R2", "a inv=1 ni=0", drive_a, 1'b0);
    inv = 0; noninv = 0; idle(6);
    chk("R2", "b inv=0 ni=0", drive_b, 1'b0);
    idle(30);

    cur_req = "R9";
    noninv = 1; idle(2);
    chk("R9", "a after 2 clocks", drive_a, 1'b0);
    idle(1);
    chk("R3", "a parallel", drive_a, 1'b1);
    chk("R3", "b parallel", drive_b, 1'b1);
    idle(5);
    noninv = 0; idle(2);
    chk("R9", "a still on after 2 clocks", drive_a, 1'b1);
    idle(1);
    chk("R9", "a off after 3 clocks", drive_a, 1'b0);
    idle(30);

    cur_req = "R3";
    noninv = 1; idle(4); noninv = 0; idle(30);
    noninv = 1; idle(10);
    chk("R3", "b long pulse", drive_b, 1'b1);
    noninv = 0; idle(30);

    cur_req = "R4";
    alt = 1; idle(30);
    for (int p = 0; p < 4; p++) begin
      noninv = 1; idle(4);
      chk("R4", "a alternating", drive_a, (p % 2 == 0));
      chk("R4", "b alternating", drive_b, (p % 2 == 1));
      noninv = 0; idle(30);
      chk("R4", "sel after pulse", sel_b, (p % 2 == 0));
    end

    cur_req = "R5";
    noninv = 1; idle(6); noninv = 0; idle(5);
    noninv = 1; idle(6);
    chk("R5", "a rejected pulse", drive_a, 1'b0);
    chk("R5", "b rejected pulse", drive_b, 1'b0);
    noninv = 0; idle(4);
    chk("R5", "sel after rejected pulse", sel_b, 1'b1);
    idle(30);
    noninv = 1; idle(4);
    chk("R5", "b after long gap", drive_b, 1'b1);
    noninv = 0; idle(30);

    cur_req = "R6";
    noninv = 1; idle(5);
    chk("R6", "a before stop", drive_a, 1'b1);
    stp = 1; idle(1); stp = 0; idle(4);
    chk("R6", "a after stop", drive_a, 1'b0);
    chk("R6", "latched", stop_l, 1'b1);
    noninv = 0; idle(12);
    chk("R6", "latched within off-time", stop_l, 1'b1);
    idle(25);
    chk("R6", "released after off-time", stop_l, 1'b0);
    noninv = 1; idle(4);
    chk("R6", "b after release", drive_b, 1'b1);
    noninv = 0; idle(30);

    cur_req = "R7";
    noninv = 1; idle(4);
    chk("R7", "a before overtemp", drive_a, 1'b1);
    ot = 1; idle(3);
    chk("R7", "a during overtemp", drive_a, 1'b0);
    ot = 0; idle(3);
    chk("R7", "a after overtemp", drive_a, 1'b1);
    noninv = 0; idle(30);

    cur_req = "R8";
    inh_a = 1; noninv = 1; idle(4);
    chk("R8", "b with inhibit a", drive_b, 1'b1);
    inh_b = 1; idle(3);
    chk("R8", "b with inhibit b", drive_b, 1'b0);
    inh_b = 0; idle(3);
    chk("R8", "b after inhibit b", drive_b, 1'b1);
    noninv = 0; inh_a = 0; idle(30);
    alt = 0; idle(5);
    noninv = 1; inh_a = 1; idle(4);
    chk("R8", "a inhibited parallel", drive_a, 1'b0);
    chk("R8", "b free parallel", drive_b, 1'b1);
    noninv = 0; inh_a = 0; idle(30);

    done = 1;
    summary();
    $finish;
  end
endmodule